// File: doc/BRIEF.md
# Table Pointer Access Unit

This block moves single bytes between an 8-bit holding latch and a byte-wide program-memory port. A 21-bit pointer supplies the memory address. The block accepts a 16-bit opcode. Eight consecutive opcode values select a transfer: a read copies a memory byte into the latch, and a write stores the latch into memory. Each transfer also selects how the pointer moves: it stays put, it steps up or down after the access, or it steps up before the access.

Every accepted transfer produces exactly one memory request. The request is a single-cycle strobe that carries the address, a direction flag and the write byte. A read returns its byte one cycle after the strobe, and the latch captures it at the end of that cycle.

A small state machine sequences the work. Its states are:

- `ST_IDLE`, which accepts work.
- `ST_ISSUE`, which drives the strobe.
- `ST_CAPTURE`, which loads read data.

Its transitions are:

- IDLE→ISSUE on an accepted opcode.
- ISSUE→CAPTURE on a read.
- ISSUE→IDLE on a write.
- CAPTURE→IDLE always.

The pointer and the latch can also be loaded directly through a register-write port while the block is idle.

Top module: `tau_top`

## Requirements
- R1: After reset, the pointer and the latch are zero, and `busy` and `mem_req` are low.
- R2: While idle, `reg_we` with `reg_sel`=0 loads the pointer from `reg_wdata[20:0]`. With `reg_sel`=1 it loads the latch from `reg_wdata[7:0]`. The new value is visible on the next cycle.
- R3: Opcodes 0x0008–0x000B are reads and 0x000C–0x000F are writes. Bit 2 is 1 for a write. Bits [1:0] select the pointer mode: 00 hold, 01 post-increment, 10 post-decrement, 11 pre-increment.
- R4: An opcode accepted while idle produces exactly one `mem_req` pulse, one cycle wide, in the cycle after acceptance.
- R5: In hold, post-increment and post-decrement modes, the access uses the old pointer. The pointer then becomes old, old+1 or old−1 respectively, and is visible in the strobe cycle.
- R6: In pre-increment mode, both the pointer and the access address become old+1.
- R7: A write strobe asserts `mem_we` and carries the current latch value on `mem_wdata`.
- R8: A read strobe has `mem_we` low. The latch takes `mem_rdata` from the cycle after the strobe. `busy` stays high through the strobe cycle and that following cycle.
- R9: The pointer wraps modulo 2^21 in both directions.
- R10: An opcode outside 0x0008–0x000F issues no request and changes neither the pointer nor the latch.
- R11: While `busy` is high, `op_valid` and `reg_we` are ignored.
- R12: If an accepted opcode and `reg_we` arrive in the same idle cycle, the opcode is performed and the register write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Opcode present this cycle |
| op_code | input | 16 | Opcode word |
| reg_we | input | 1 | Direct register write strobe |
| reg_sel | input | 1 | 0 selects the pointer, 1 selects the latch |
| reg_wdata | input | 21 | Direct write value |
| ptr_q | output | 21 | Current table pointer |
| latch_q | output | 8 | Current table latch |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 for a write access |
| mem_addr | output | 21 | Access address |
| mem_wdata | output | 8 | Byte to store |
| mem_rdata | input | 8 | Byte returned one cycle after a read strobe |

## Verification
The bench builds the block with its default widths: a 21-bit pointer, an 8-bit latch, a 16-bit opcode and an opcode base of 0x0008. Keeping the full 21-bit pointer lets a direct load reach 0x1FFFFF, so both wrap directions are reached in a few transfers. The backing memory is indexed by the low address byte, so read data stays meaningful at either wrap point. Ignored stimulus is placed in busy cycles and next to an accepted opcode, and it is then checked through the pointer and latch outputs and the absence of extra strobes.

// File: rtl/tau_pkg.sv
package tau_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ISSUE   = 2'd1,
        ST_CAPTURE = 2'd2
    } tau_state_t;

    typedef enum logic [1:0] {
        MD_HOLD    = 2'd0,
        MD_POSTINC = 2'd1,
        MD_POSTDEC = 2'd2,
        MD_PREINC  = 2'd3
    } tau_mode_t;

    typedef struct packed {
        logic      ok;
        logic      is_write;
        tau_mode_t mode;
    } tau_dec_t;

endpackage

// File: rtl/tau_decode.sv
module tau_decode
    import tau_pkg::*;
#(
    parameter int          OP_W    = 16,
    parameter logic [15:0] OP_BASE = 16'h0008
) (
    input  logic [OP_W-1:0] op_code,
    output tau_dec_t        dec
);
    localparam int          HI_W    = OP_W - 3;
    localparam logic [HI_W-1:0] BASE_HI = HI_W'(OP_BASE >> 3);

    always_comb begin
        dec.ok       = (op_code[OP_W-1:3] == BASE_HI);
        dec.is_write = op_code[2];
        dec.mode     = tau_mode_t'(op_code[1:0]);
    end
endmodule

// File: rtl/tau_ptr_math.sv
module tau_ptr_math
    import tau_pkg::*;
#(
    parameter int PTR_W = 21
) (
    input  logic [PTR_W-1:0] ptr_cur,
    input  tau_mode_t        mode,
    output logic [PTR_W-1:0] acc_addr,
    output logic [PTR_W-1:0] ptr_next
);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    logic [PTR_W-1:0] up;
    logic [PTR_W-1:0] down;

    always_comb begin
        up   = ptr_cur + ONE;
        down = ptr_cur - ONE;
        unique case (mode)
            MD_HOLD: begin
                acc_addr = ptr_cur;
                ptr_next = ptr_cur;
            end
            MD_POSTINC: begin
                acc_addr = ptr_cur;
                ptr_next = up;
            end
            MD_POSTDEC: begin
                acc_addr = ptr_cur;
                ptr_next = down;
            end
            MD_PREINC: begin
                acc_addr = up;
                ptr_next = up;
            end
            default: begin
                acc_addr = ptr_cur;
                ptr_next = ptr_cur;
            end
        endcase
    end
endmodule

// File: rtl/tau_ctrl.sv
module tau_ctrl
    import tau_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_valid,
    input  logic op_ok,
    input  logic op_write,
    input  logic reg_we,
    output logic accept,
    output logic reg_ok,
    output logic issue,
    output logic capture,
    output logic busy
);
    tau_state_t state_q;
    tau_state_t state_d;
    logic       wr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) wr_q <= op_write;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = ST_ISSUE;
            ST_ISSUE:   state_d = wr_q ? ST_IDLE : ST_CAPTURE;
            ST_CAPTURE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept  = 1'b0;
        reg_ok  = 1'b0;
        issue   = 1'b0;
        capture = 1'b0;
        busy    = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy   = 1'b0;
                accept = op_valid && op_ok;
                reg_ok = reg_we && !(op_valid && op_ok);
            end
            ST_ISSUE:   issue   = 1'b1;
            ST_CAPTURE: capture = 1'b1;
            default:    busy    = 1'b1;
        endcase
    end
endmodule

// File: rtl/tau_top.sv
module tau_top
    import tau_pkg::*;
#(
    parameter int          PTR_W   = 21,
    parameter int          DAT_W   = 8,
    parameter int          OP_W    = 16,
    parameter logic [15:0] OP_BASE = 16'h0008
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [OP_W-1:0]  op_code,
    input  logic             reg_we,
    input  logic             reg_sel,
    input  logic [PTR_W-1:0] reg_wdata,
    output logic [PTR_W-1:0] ptr_q,
    output logic [DAT_W-1:0] latch_q,
    output logic             busy,
    output logic             mem_req,
    output logic             mem_we,
    output logic [PTR_W-1:0] mem_addr,
    output logic [DAT_W-1:0] mem_wdata,
    input  logic [DAT_W-1:0] mem_rdata
);
    tau_dec_t         dec;
    logic [PTR_W-1:0] acc_addr;
    logic [PTR_W-1:0] ptr_next;
    logic             accept;
    logic             reg_ok;
    logic             issue;
    logic             capture;

    tau_decode #(.OP_W(OP_W), .OP_BASE(OP_BASE)) u_dec (
        .op_code (op_code),
        .dec     (dec)
    );

    tau_ptr_math #(.PTR_W(PTR_W)) u_math (
        .ptr_cur  (ptr_q),
        .mode     (dec.mode),
        .acc_addr (acc_addr),
        .ptr_next (ptr_next)
    );

    tau_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_ok    (dec.ok),
        .op_write (dec.is_write),
        .reg_we   (reg_we),
        .accept   (accept),
        .reg_ok   (reg_ok),
        .issue    (issue),
        .capture  (capture),
        .busy     (busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q     <= '0;
            latch_q   <= '0;
            mem_addr  <= '0;
            mem_we    <= 1'b0;
            mem_wdata <= '0;
        end else begin
            if (accept) begin
                ptr_q     <= ptr_next;
                mem_addr  <= acc_addr;
                mem_we    <= dec.is_write;
                mem_wdata <= latch_q;
            end else if (reg_ok) begin
                if (reg_sel) latch_q <= reg_wdata[DAT_W-1:0];
                else         ptr_q   <= reg_wdata;
            end
            if (capture) latch_q <= mem_rdata;
        end
    end

    assign mem_req = issue;
endmodule

// File: rtl/tau_checker.sv
module tau_checker #(
    parameter int PTR_W = 21,
    parameter int DAT_W = 8,
    parameter int OP_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [OP_W-1:0]  op_code,
    input logic             reg_we,
    input logic [PTR_W-1:0] ptr_q,
    input logic [DAT_W-1:0] latch_q,
    input logic             busy,
    input logic             mem_req,
    input logic             mem_we,
    input logic [DAT_W-1:0] mem_wdata
);
    logic in_range;
    assign in_range = (op_code >= OP_W'(8)) && (op_code <= OP_W'(15));

    p_one_cycle_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    p_accept_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && in_range) |=> mem_req);

    p_busy_with_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    p_read_holds_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> busy);

    p_write_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata == latch_q));

    p_ptr_hold_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ptr_q));

    p_invalid_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && !in_range && !reg_we) |=>
            (!mem_req && $stable(ptr_q) && $stable(latch_q)));
endmodule

bind tau_top tau_checker #(.PTR_W(PTR_W), .DAT_W(DAT_W), .OP_W(OP_W)) u_tau_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .reg_we    (reg_we),
    .ptr_q     (ptr_q),
    .latch_q   (latch_q),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata)
);

// File: tb/tau_top_bench.sv
module tau_top_bench;
    localparam int PTR_W = 21;
    localparam int DAT_W = 8;
    localparam logic [PTR_W-1:0] PMAX = {PTR_W{1'b1}};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             op_valid = 1'b0;
    logic [15:0]      op_code = '0;
    logic             reg_we = 1'b0;
    logic             reg_sel = 1'b0;
    logic [PTR_W-1:0] reg_wdata = '0;
    logic [PTR_W-1:0] ptr_q;
    logic [DAT_W-1:0] latch_q;
    logic             busy;
    logic             mem_req;
    logic             mem_we;
    logic [PTR_W-1:0] mem_addr;
    logic [DAT_W-1:0] mem_wdata;
    logic [DAT_W-1:0] mem_rdata = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tau_top u_tau_top (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .ptr_q(ptr_q), .latch_q(latch_q), .busy(busy), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // memory behind the port, indexed by the low address byte
    logic [7:0] memarr [256];
    // bench model of the same storage
    logic [7:0] exp_mem [256];
    initial begin
        for (int i = 0; i < 256; i++) begin
            memarr[i]  = 8'(i * 13 + 7);
            exp_mem[i] = 8'(i * 13 + 7);
        end
    end
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) memarr[mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= memarr[mem_addr[7:0]];
        end
    end

    typedef struct {
        logic [PTR_W-1:0] addr;
        logic             we;
        logic [7:0]       wdata;
        string            tag;
    } req_t;
    req_t exp_q[$];

    logic [PTR_W-1:0] m_ptr = '0;
    logic [7:0]       m_lat = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: compares every strobe against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && mem_req && !done) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R10/R11: actual unexpected request addr %0h expected none", mem_addr);
            end else begin
                req_t e;
                e = exp_q.pop_front();
                chk({e.tag, " addr"}, 32'(mem_addr), 32'(e.addr));
                chk({e.tag, " we"}, 32'(mem_we), 32'(e.we));
                if (e.we) chk({e.tag, " R7 wdata"}, 32'(mem_wdata), 32'(e.wdata));
            end
        end
    end

    // compute expected result of an opcode from the requirements, push it
    task automatic model(input logic [15:0] op, input string tag);
        logic [PTR_W-1:0] a;
        if (op[15:3] != 13'h1) return;
        unique case (op[1:0])
            2'b00: a = m_ptr;
            2'b01: begin a = m_ptr; m_ptr = m_ptr + 1'b1; end
            2'b10: begin a = m_ptr; m_ptr = m_ptr - 1'b1; end
            default: begin m_ptr = m_ptr + 1'b1; a = m_ptr; end
        endcase
        exp_q.push_back('{addr: a, we: op[2], wdata: m_lat, tag: tag});
        if (op[2]) exp_mem[a[7:0]] = m_lat;
        else       m_lat = exp_mem[a[7:0]];
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic do_op(input logic [15:0] op, input string tag);
        model(op, tag);
        @(negedge clk);
        op_valid = 1'b1; op_code = op;
        @(negedge clk);
        op_valid = 1'b0;
        wait_idle();
        chk({tag, " ptr"}, 32'(ptr_q), 32'(m_ptr));
        chk({tag, " latch"}, 32'(latch_q), 32'(m_lat));
    endtask

    task automatic reg_wr(input logic sel, input logic [PTR_W-1:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
        if (sel) m_lat = v[7:0]; else m_ptr = v;
        chk("R2 direct load", sel ? 32'(latch_q) : 32'(ptr_q), sel ? 32'(v[7:0]) : 32'(v));
    endtask

    initial begin
        #(200000 * 10);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ptr", 32'(ptr_q), 0);
        chk("R1 latch", 32'(latch_q), 0);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 req", 32'(mem_req), 0);
        rst_n = 1'b1;
        @(negedge clk);

        reg_wr(1'b0, 21'h000010);
        // R3 R5 R8: read modes
        do_op(16'h0008, "R3 R5 R8 read hold");
        do_op(16'h0009, "R5 read postinc");
        do_op(16'h000A, "R5 read postdec");
        do_op(16'h000B, "R6 read preinc");
        // R3 R7: write modes
        reg_wr(1'b1, 21'h00005A);
        do_op(16'h000C, "R7 write hold");
        reg_wr(1'b1, 21'h0000C3);
        do_op(16'h000D, "R5 write postinc");
        do_op(16'h000E, "R5 write postdec");
        reg_wr(1'b1, 21'h000031);
        do_op(16'h000F, "R6 write preinc");
        // read back what was stored
        do_op(16'h000A, "R7 readback");
        do_op(16'h0008, "R7 readback2");
        // R9 wrap both ways
        reg_wr(1'b0, PMAX);
        do_op(16'h0009, "R9 postinc wrap");
        chk("R9 ptr zero", 32'(ptr_q), 0);
        do_op(16'h000A, "R9 postdec wrap");
        chk("R9 ptr max", 32'(ptr_q), 32'(PMAX));
        do_op(16'h000B, "R9 preinc wrap");
        // R10 invalid opcodes
        do_op(16'h0007, "R10 below");
        do_op(16'h0010, "R10 above");
        do_op(16'h8008, "R10 high bit");
        do_op(16'h0000, "R10 zero");
        // R11: stimulus during busy is ignored
        reg_wr(1'b0, 21'h000040);
        model(16'h0009, "R11 first");
        @(negedge clk);
        op_valid = 1'b1; op_code = 16'h0009;
        @(negedge clk);
        op_code = 16'h000C; reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 21'h000777;
        @(negedge clk);
        reg_sel = 1'b1;
        @(negedge clk);
        op_valid = 1'b0; reg_we = 1'b0;
        wait_idle();
        chk("R11 ptr", 32'(ptr_q), 32'(m_ptr));
        chk("R11 latch", 32'(latch_q), 32'(m_lat));
        // R12: opcode wins over simultaneous register write
        model(16'h0009, "R12 op");
        @(negedge clk);
        op_valid = 1'b1; op_code = 16'h0009;
        reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 21'h000123;
        @(negedge clk);
        op_valid = 1'b0; reg_we = 1'b0;
        wait_idle();
        chk("R12 ptr", 32'(ptr_q), 32'(m_ptr));
        chk("R12 latch", 32'(latch_q), 32'(m_lat));
        repeat (3) @(negedge clk);
        chk("R4 all strobes seen", 32'(exp_q.size()), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule